// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim and Complete

This block gathers 31 level-sensitive interrupt requests and routes them to two hart contexts. Each source has a 3-bit priority. Each context has its own enable mask, its own 3-bit threshold and its own claim/complete word. A context raises its interrupt line while at least one source is pending, is enabled for that context, and has a priority strictly above that context's threshold.

Software services an interrupt in two steps. It reads the context's claim word, which returns the winning source ID and takes that source out of the pending state. It then writes the same ID back to the claim word. Between those two steps the source is held busy and its request line is disregarded. Software repeats claim reads until one returns 0.

Each source has a small gateway state machine with three states:
- GW_IDLE: waiting for a request.
- GW_PEND: pending.
- GW_BUSY: claimed, awaiting completion.

Its transitions are:
- req_seen: GW_IDLE to GW_PEND, taken when the input is high.
- claimed: GW_PEND to GW_BUSY, taken on a claim read that selects this source.
- completed: GW_BUSY to GW_IDLE, taken on a valid completion write.

The register bus is synchronous and addressed in 32-bit words.

Top module: `plic_top`

## Requirements
- R1: After reset every priority, enable mask and threshold is zero, both `irq_o` bits are low, and a claim read returns 0.
- R2: Source n (1..31) has its priority at word address n, 3 bits wide, with the upper bits reading 0. Word 0 always reads 0 and ignores writes.
- R3: The enable mask of context c is at word 0x800 + c*0x20. Bit n enables source n. Bit 0 always reads 0.
- R4: The threshold of context c is at word 0x80000 + c*0x400, 3 bits wide. Its upper bits read 0.
- R5: `irq_o[c]` is high exactly when some source is pending, is enabled in context c, and has a priority strictly greater than threshold c. A priority of 0 never signals, and a threshold of 7 masks every source.
- R6: A high level on `src_i[n-1]` makes an idle source n pending at the next clock edge. The source stays pending after the input drops, until it is claimed.
- R7: A read of word 0x80001 + c*0x400 (the claim word) returns the qualifying source for context c. The winner is the source with the highest priority, with ties going to the lowest ID. The read returns 0 when no source qualifies, and it clears the pending state of the returned source.
- R8: A claimed source ignores its input, and it cannot become pending again until it is completed.
- R9: Writing ID n to the claim word of context c completes source n, so that it can become pending again from the next edge. The write is ignored if source n is not enabled in context c, or if the value written is not in the range 1..31.
- R10: Read data appears on `bus_rdata_o` in the cycle after `bus_rd_i`. Unmapped words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 31 | Level requests; bit n-1 belongs to source n |
| bus_wr_i | input | 1 | Word write strobe |
| bus_rd_i | input | 1 | Word read strobe |
| bus_addr_i | input | 20 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| irq_o | output | 2 | Interrupt line per context |

## Verification
The assertions assume that reads and writes never coincide in one cycle. They also assume that a claim read is the only event that moves a source out of the pending state. The stimulus enforces the first assumption by issuing every bus access from a single task, with one strobe per cycle. It stays within the second by changing source inputs only on falling clock edges.

// File: rtl/plic_pkg.sv
package plic_pkg;
    localparam int NSRC   = 31;
    localparam int NCTX   = 2;
    localparam int PRIO_W = 3;
    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int ADDR_W = 20;

    localparam int PRIO_BASE_B  = 32'h0;
    localparam int EN_BASE_B    = 32'h2000;
    localparam int EN_STRIDE_B  = 32'h80;
    localparam int CTX_BASE_B   = 32'h200000;
    localparam int CTX_STRIDE_B = 32'h1000;

    typedef enum logic [1:0] {GW_IDLE, GW_PEND, GW_BUSY} gw_state_e;

    function automatic logic [ADDR_W-1:0] prio_word(int n);
        return ADDR_W'(PRIO_BASE_B / 4 + n);
    endfunction

    function automatic logic [ADDR_W-1:0] en_word(int c);
        return ADDR_W'((EN_BASE_B + c * EN_STRIDE_B) / 4);
    endfunction

    function automatic logic [ADDR_W-1:0] thr_word(int c);
        return ADDR_W'((CTX_BASE_B + c * CTX_STRIDE_B) / 4);
    endfunction

    function automatic logic [ADDR_W-1:0] clm_word(int c);
        return ADDR_W'((CTX_BASE_B + c * CTX_STRIDE_B) / 4 + 1);
    endfunction
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pend_o
);
    gw_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (req_i)      state_d = GW_PEND;
            GW_PEND: if (claim_i)    state_d = GW_BUSY;
            GW_BUSY: if (complete_i) state_d = GW_IDLE;
            default:                 state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == GW_PEND);
    end
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5
) (
    input  logic [NSRC:1]             cand_i,
    input  logic [NSRC:1][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thr_i,
    output logic [ID_W-1:0]           win_id_o,
    output logic                      win_vld_o
);
    logic [PRIO_W-1:0] best;

    // ascending scan with strict compare: ties keep the lowest ID
    always_comb begin
        best      = thr_i;
        win_id_o  = '0;
        win_vld_o = 1'b0;
        for (int n = 1; n <= NSRC; n++) begin
            if (cand_i[n] && (prio_i[n] > best)) begin
                best      = prio_i[n];
                win_id_o  = ID_W'(n);
                win_vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/plic_top.sv
module plic_top
    import plic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic [NCTX-1:0]   irq_o
);
    logic [NSRC:1][PRIO_W-1:0]          prio_q;
    logic [NCTX-1:0][NSRC:1]            en_q;
    logic [NCTX-1:0][PRIO_W-1:0]        thr_q;
    logic [NSRC:1]                      pend_w;
    logic [NSRC:1]                      claim_vec;
    logic [NSRC:1]                      done_vec;
    logic [NCTX-1:0][ID_W-1:0]          win_id;
    logic [NCTX-1:0]                    win_vld;
    logic [31:0]                        rd_mux;
    logic [31:0]                        rdata_q;

    for (genvar g = 1; g <= NSRC; g++) begin : g_gw
        plic_gateway u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (src_i[g-1]),
            .claim_i    (claim_vec[g]),
            .complete_i (done_vec[g]),
            .pend_o     (pend_w[g])
        );
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        plic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
            .cand_i    (pend_w & en_q[c]),
            .prio_i    (prio_q),
            .thr_i     (thr_q[c]),
            .win_id_o  (win_id[c]),
            .win_vld_o (win_vld[c])
        );
        assign irq_o[c] = win_vld[c];
    end

    always_comb begin
        claim_vec = '0;
        done_vec  = '0;
        for (int c = 0; c < NCTX; c++) begin
            for (int n = 1; n <= NSRC; n++) begin
                if (bus_rd_i && bus_addr_i == clm_word(c) && win_vld[c]
                    && win_id[c] == ID_W'(n))
                    claim_vec[n] = 1'b1;
                if (bus_wr_i && bus_addr_i == clm_word(c) && en_q[c][n]
                    && bus_wdata_i == 32'(n))
                    done_vec[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (bus_wr_i) begin
            for (int n = 1; n <= NSRC; n++)
                if (bus_addr_i == prio_word(n)) prio_q[n] <= bus_wdata_i[PRIO_W-1:0];
            for (int c = 0; c < NCTX; c++) begin
                if (bus_addr_i == en_word(c))  en_q[c]  <= bus_wdata_i[NSRC:1];
                if (bus_addr_i == thr_word(c)) thr_q[c] <= bus_wdata_i[PRIO_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int n = 1; n <= NSRC; n++)
            if (bus_addr_i == prio_word(n)) rd_mux = 32'(prio_q[n]);
        for (int c = 0; c < NCTX; c++) begin
            if (bus_addr_i == en_word(c))  rd_mux = 32'({en_q[c], 1'b0});
            if (bus_addr_i == thr_word(c)) rd_mux = 32'(thr_q[c]);
            if (bus_addr_i == clm_word(c)) rd_mux = 32'(win_id[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_mux;
        else               rdata_q <= '0;
    end

    assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/plic_chk.sv
module plic_chk
    import plic_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_rd_i,
    input logic [ADDR_W-1:0]           bus_addr_i,
    input logic [31:0]                 bus_rdata_o,
    input logic [NCTX-1:0]             irq_o,
    input logic [NCTX-1:0][PRIO_W-1:0] thr_q,
    input logic [NSRC:1][PRIO_W-1:0]   prio_q,
    input logic [NSRC:1]               pend_w,
    input logic [NSRC:1]               claim_vec,
    input logic [NCTX-1:0][ID_W-1:0]   win_id,
    input logic [NCTX-1:0]             win_vld
);
    for (genvar c = 0; c < NCTX; c++) begin : g_c
        // R5
        thr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_q[c] == '1) |-> !irq_o[c]);
        // R5
        prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            win_vld[c] |-> (win_id[c] != '0 && prio_q[win_id[c]] != '0));
        // R7
        claim_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd_i && bus_addr_i == clm_word(c) && !irq_o[c]) |=> (bus_rdata_o == 32'd0));
        // R7
        claim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd_i && bus_addr_i == clm_word(c) && irq_o[c]) |=> (bus_rdata_o != 32'd0));
    end
    for (genvar n = 1; n <= NSRC; n++) begin : g_n
        // R8
        claim_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            claim_vec[n] |=> !pend_w[n]);
    end
endmodule

bind plic_top plic_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .thr_q       (thr_q),
    .prio_q      (prio_q),
    .pend_w      (pend_w),
    .claim_vec   (claim_vec),
    .win_id      (win_id),
    .win_vld     (win_vld)
);

// File: tb/plic_top_tb_top.sv
module plic_top_tb_top;
    import plic_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src = '0;
    logic              wr = 1'b0, rd = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCTX-1:0]   irq;
    int                checks = 0, errors = 0;
    bit                done = 1'b0;

    always #4 clk = ~clk;

    plic_top dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    localparam logic [ADDR_W-1:0] EN0 = 20'h00800, EN1 = 20'h00820;
    localparam logic [ADDR_W-1:0] TH0 = 20'h80000, CL0 = 20'h80001;
    localparam logic [ADDR_W-1:0] TH1 = 20'h80400, CL1 = 20'h80401;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bwrite(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bread(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic set_src(int n, logic v);
        @(negedge clk); src[n-1] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", 32'(irq), 0);
        bread(20'd5, d); check("R1 prio", d, 0);
        bread(EN0, d);   check("R1 enable", d, 0);
        bread(TH1, d);   check("R1 threshold", d, 0);
        bread(CL0, d);   check("R1 claim", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bwrite(20'd3, 32'hFFFF_FFFF); bread(20'd3, d); check("R2 prio width", d, 7);
        bwrite(20'd0, 32'hFFFF_FFFF); bread(20'd0, d); check("R2 word 0", d, 0);
        bwrite(EN1, 32'hFFFF_FFFF);   bread(EN1, d);   check("R3 enable bit0", d, 32'hFFFF_FFFE);
        bwrite(TH0, 32'hFF);          bread(TH0, d);   check("R4 threshold width", d, 7);
        bread(20'h00040, d); check("R10 unmapped", d, 0);
        bwrite(20'd3, 0); bwrite(EN1, 0); bwrite(TH0, 0);
    endtask

    task automatic t_arbitrate();
        logic [31:0] d;
        bwrite(20'd3, 2); bwrite(20'd5, 5); bwrite(20'd9, 5);
        bwrite(EN0, (1 << 3) | (1 << 5) | (1 << 9)); bwrite(TH0, 1);
        @(negedge clk); src[2] = 1'b1; src[4] = 1'b1; src[8] = 1'b1;
        @(negedge clk);
        check("R5 irq0 high", 32'(irq[0]), 1);
        check("R5 irq1 not enabled", 32'(irq[1]), 0);
        bread(CL0, d); check("R7 tie lowest id", d, 5);
        bread(CL0, d); check("R7 next equal prio", d, 9);
        bread(CL0, d); check("R7 lower prio", d, 3);
        bread(CL0, d); check("R7 empty claim", d, 0);
        repeat (2) @(negedge clk);
        check("R8 busy ignores input", 32'(irq[0]), 0);
        bwrite(CL1, 5); @(negedge clk);
        check("R9 completion wrong ctx", 32'(irq[0]), 0);
        bwrite(CL0, 5); @(negedge clk);
        check("R9 re-armed", 32'(irq[0]), 1);
        bread(CL0, d); check("R9 claim again", d, 5);
        src = '0;
        bwrite(CL0, 5); bwrite(CL0, 9); bwrite(CL0, 3); bwrite(CL0, 0);
        @(negedge clk);
        check("R9 all completed quiet", 32'(irq[0]), 0);
    endtask

    task automatic t_threshold();
        logic [31:0] d;
        set_src(5, 1'b1); set_src(5, 1'b0);
        check("R6 held after drop", 32'(irq[0]), 1);
        bwrite(TH0, 5); check("R5 strict compare", 32'(irq[0]), 0);
        bwrite(TH0, 4); check("R5 above threshold", 32'(irq[0]), 1);
        bwrite(TH0, 7); check("R5 threshold max masks", 32'(irq[0]), 0);
        bwrite(TH0, 0);
        bread(CL0, d); check("R7 claim after mask", d, 5);
        bwrite(CL0, 5);
        bwrite(20'd7, 0); bwrite(EN0, 1 << 7);
        set_src(7, 1'b1); set_src(7, 1'b0);
        check("R5 prio zero silent", 32'(irq[0]), 0);
        bread(CL0, d); check("R5 prio zero not claimed", d, 0);
        bwrite(20'd7, 1);
        check("R6 pending kept", 32'(irq[0]), 1);
        bread(CL0, d); check("R6 claim latched source", d, 7);
        bwrite(CL0, 7);
    endtask

    task automatic t_contexts();
        logic [31:0] d;
        bwrite(20'd12, 3); bwrite(EN1, 1 << 12); bwrite(TH1, 2);
        set_src(12, 1'b1); set_src(12, 1'b0);
        check("R5 ctx0 low", 32'(irq[0]), 0);
        check("R5 ctx1 high", 32'(irq[1]), 1);
        bread(CL0, d); check("R7 other ctx claim", d, 0);
        bread(CL1, d); check("R7 ctx1 claim", d, 12);
        bwrite(CL0, 12);
        set_src(12, 1'b1); set_src(12, 1'b0);
        check("R9 not enabled completion ignored", 32'(irq[1]), 0);
        bwrite(CL1, 12);
        set_src(12, 1'b1); set_src(12, 1'b0);
        check("R9 ctx1 completion", 32'(irq[1]), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_arbitrate();
        t_threshold();
        t_contexts();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule